// File: doc/BRIEF.md
# Software Security Level Controller

This block holds a one-byte protection level for an in-system programming engine. It judges every operation that engine is about to carry out. The engine presents an operation code together with a strobe. In the same cycle the block answers with a grant, or with a denial and the ASCII character that the engine sends back to the host. The engine appends the line terminator (CR, LF) to that character itself. The stored level can only move toward stronger protection, through security writes. The single way back to the open level is a full chip erase. A full erase also raises a one-cycle pulse, which tells the neighbouring configuration logic to reload its boot-status and boot-vector defaults.

The judgement is combinational and nothing is queued, so the block never applies back-pressure. It has no valid/ready channel. Every pin is a plain control or status signal, and a strobe is consumed in the cycle it is high.

Top module: `sec_level_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `sec_level` is 0xFF, `cfg_restore` is 0, and `grant`, `deny` and `err_char` are 0.
- R2: At level 0xFF (open), every operation code is granted. A security write is the one exception and follows R6/R7.
- R3: At level 0xFE (write-locked), memory read (code 0) is granted. Memory write (1), block erase (2) and configuration write (4) are denied with `err_char` 0x50 ('P').
- R4: At level 0xFC (read/write-locked), memory read (0) is denied with 0x4C ('L'). Memory write (1), block erase (2) and configuration write (4) are denied with 0x50 ('P').
- R5: Full erase (3), information read (6) and blank check (7) are granted at every level.
- R6: A security write (5) is granted only when `req_level` is 0xFE or 0xFC and ranks above the stored level, in the order 0xFF < 0xFE < 0xFC. On the next clock edge `sec_level` takes `req_level`.
- R7: A security write with an unrecognised value, or one that lowers or repeats the stored level, is denied with 0x50 ('P'), and `sec_level` does not change.
- R8: A strobed full erase sets `sec_level` to 0xFF on the next edge, and `cfg_restore` is high for exactly that one following cycle.
- R9: `grant`, `deny` and `err_char` follow the current inputs and stored level in the same cycle. With `op_valid` low they are all 0 and `sec_level` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Strobe: an operation is presented this cycle |
| op_code | input | 3 | Operation code (0 mem read, 1 mem write, 2 block erase, 3 full erase, 4 cfg write, 5 security write, 6 info read, 7 blank check) |
| req_level | input | 8 | Requested level for a security write |
| grant | output | 1 | Operation permitted (combinational) |
| deny | output | 1 | Operation refused (combinational) |
| err_char | output | 8 | 'P' or 'L' on refusal, 0 otherwise |
| sec_level | output | 8 | Stored protection level |
| cfg_restore | output | 1 | One-cycle pulse after a full erase |

## Verification
The state that is hardest to reach from the ports is the read/write-locked level after a chain of refused attempts. Getting there requires sequenced security writes, and the only way out is a full erase. The stimulus climbs through every legal and illegal step in order: 0xFF to 0xFE to 0xFC, plus lowering, repeated and unrecognised values. It sweeps every opcode at each level and erases back to open. A pseudo-random phase then mixes strobes, opcodes and levels. A behavioural model in the bench compares the results on every clock.

// File: rtl/sec_lvl_pkg.sv
package sec_lvl_pkg;

  typedef enum logic [2:0] {
    OPC_MEM_RD     = 3'd0,
    OPC_MEM_WR     = 3'd1,
    OPC_BLK_ERASE  = 3'd2,
    OPC_FULL_ERASE = 3'd3,
    OPC_CFG_WR     = 3'd4,
    OPC_SEC_WR     = 3'd5,
    OPC_INFO_RD    = 3'd6,
    OPC_BLANK      = 3'd7
  } sec_op_e;

  // Protection strength, ordered so that a larger value means stronger locking.
  typedef enum logic [1:0] {
    RANK_OPEN   = 2'd0,
    RANK_WRLOCK = 2'd1,
    RANK_RWLOCK = 2'd2,
    RANK_BAD    = 2'd3
  } sec_rank_e;

  localparam logic [7:0] ERR_CHAR_WRITE = 8'h50;  // 'P'
  localparam logic [7:0] ERR_CHAR_READ  = 8'h4C;  // 'L'

endpackage

// File: rtl/sec_rank_decode.sv
module sec_rank_decode
  import sec_lvl_pkg::*;
#(
  parameter int unsigned     LVL_W      = 8,
  parameter logic [LVL_W-1:0] LVL_OPEN   = 8'hFF,
  parameter logic [LVL_W-1:0] LVL_WRLOCK = 8'hFE,
  parameter logic [LVL_W-1:0] LVL_RWLOCK = 8'hFC
) (
  input  logic [LVL_W-1:0] code,
  output sec_rank_e        rank
);

  always_comb begin
    unique case (code)
      LVL_OPEN:   rank = RANK_OPEN;
      LVL_WRLOCK: rank = RANK_WRLOCK;
      LVL_RWLOCK: rank = RANK_RWLOCK;
      default:    rank = RANK_BAD;
    endcase
  end

endmodule

// File: rtl/sec_access_matrix.sv
module sec_access_matrix
  import sec_lvl_pkg::*;
(
  input  sec_op_e   op,
  input  sec_rank_e cur_rank,
  input  sec_rank_e req_rank,
  output logic      allowed,
  output logic      read_kind
);

  logic raise_ok;

  assign raise_ok  = (req_rank != RANK_BAD) && (req_rank > cur_rank);
  assign read_kind = (op == OPC_MEM_RD);

  always_comb begin
    unique case (op)
      OPC_MEM_RD:                          allowed = (cur_rank != RANK_RWLOCK);
      OPC_MEM_WR, OPC_BLK_ERASE, OPC_CFG_WR: allowed = (cur_rank == RANK_OPEN);
      OPC_SEC_WR:                          allowed = raise_ok;
      default:                             allowed = 1'b1;  // full erase, info read, blank check
    endcase
  end

endmodule

// File: rtl/sec_level_reg.sv
module sec_level_reg #(
  parameter int unsigned      LVL_W    = 8,
  parameter logic [LVL_W-1:0] LVL_OPEN = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [LVL_W-1:0] load_val,
  input  logic             clear_en,
  output logic [LVL_W-1:0] level,
  output logic             restore_pulse
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level         <= LVL_OPEN;
      restore_pulse <= 1'b0;
    end else begin
      restore_pulse <= clear_en;
      if (clear_en)     level <= LVL_OPEN;
      else if (load_en) level <= load_val;
    end
  end

  // R8
  erase_reopens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_en |=> (level == LVL_OPEN) && restore_pulse);

  // R9
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en && !clear_en |=> $stable(level) && !restore_pulse);

endmodule

// File: rtl/sec_level_ctrl.sv
module sec_level_ctrl
  import sec_lvl_pkg::*;
#(
  parameter int unsigned      LVL_W      = 8,
  parameter logic [LVL_W-1:0] LVL_OPEN   = 8'hFF,
  parameter logic [LVL_W-1:0] LVL_WRLOCK = 8'hFE,
  parameter logic [LVL_W-1:0] LVL_RWLOCK = 8'hFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [2:0]       op_code,
  input  logic [LVL_W-1:0] req_level,
  output logic             grant,
  output logic             deny,
  output logic [7:0]       err_char,
  output logic [LVL_W-1:0] sec_level,
  output logic             cfg_restore
);

  sec_op_e   op;
  sec_rank_e cur_rank, req_rank;
  logic      allowed, read_kind;
  logic      sec_load, erase_clear;

  assign op = sec_op_e'(op_code);

  sec_rank_decode #(.LVL_W(LVL_W), .LVL_OPEN(LVL_OPEN), .LVL_WRLOCK(LVL_WRLOCK),
                    .LVL_RWLOCK(LVL_RWLOCK))
    u_cur_rank (.code(sec_level), .rank(cur_rank));

  sec_rank_decode #(.LVL_W(LVL_W), .LVL_OPEN(LVL_OPEN), .LVL_WRLOCK(LVL_WRLOCK),
                    .LVL_RWLOCK(LVL_RWLOCK))
    u_req_rank (.code(req_level), .rank(req_rank));

  sec_access_matrix u_matrix (
    .op(op), .cur_rank(cur_rank), .req_rank(req_rank),
    .allowed(allowed), .read_kind(read_kind)
  );

  assign grant    = op_valid & allowed;
  assign deny     = op_valid & ~allowed;
  assign err_char = !deny ? 8'h00 : (read_kind ? ERR_CHAR_READ : ERR_CHAR_WRITE);

  assign sec_load    = grant && (op == OPC_SEC_WR);
  assign erase_clear = grant && (op == OPC_FULL_ERASE);

  sec_level_reg #(.LVL_W(LVL_W), .LVL_OPEN(LVL_OPEN)) u_level (
    .clk(clk), .rst_n(rst_n),
    .load_en(sec_load), .load_val(req_level), .clear_en(erase_clear),
    .level(sec_level), .restore_pulse(cfg_restore)
  );

  // R6
  level_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_rank != RANK_BAD);

  // R7
  only_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_level != $past(sec_level)) && !$past(erase_clear) |-> cur_rank > $past(cur_rank));

  // R5
  always_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op == OPC_FULL_ERASE || op == OPC_INFO_RD || op == OPC_BLANK) |-> grant);

  // R4
  deny_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deny |-> (err_char == 8'h50 || err_char == 8'h4C) && !grant);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !grant && !deny && err_char == 8'h00);

endmodule

// File: tb/sec_level_ctrl_tb.sv
`timescale 1ns/100ps
module sec_level_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [2:0] op_code = 3'd0;
  logic [7:0] req_level = 8'h00;
  logic       grant, deny, cfg_restore;
  logic [7:0] err_char, sec_level;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // model state: 0 open, 1 write-locked, 2 read/write-locked
  int m_idx     = 0;
  bit m_restore = 0;
  string last_tag = "R1";

  always #2.5 clk = ~clk;

  sec_level_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .req_level(req_level), .grant(grant), .deny(deny), .err_char(err_char),
    .sec_level(sec_level), .cfg_restore(cfg_restore)
  );

  function automatic logic [7:0] idx_byte(int i);
    if (i == 0) return 8'hFF;
    if (i == 1) return 8'hFE;
    return 8'hFC;
  endfunction

  function automatic int target_of(logic [7:0] v);
    if (v == 8'hFE) return 1;
    if (v == 8'hFC) return 2;
    return -1;
  endfunction

  // 0 granted, 1 refused with 'P', 2 refused with 'L'
  function automatic int judge(int lvl, int op, logic [7:0] v);
    case (op)
      0:       return (lvl == 2) ? 2 : 0;
      1, 2, 4: return (lvl == 0) ? 0 : 1;
      5:       return (target_of(v) > lvl) ? 0 : 1;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(bit v, int lvl, int op, int verdict);
    if (!v) return "R9";
    if (op == 3) return "R8";
    if (op == 6 || op == 7) return "R5";
    if (op == 5) return (verdict == 0) ? "R6" : "R7";
    if (lvl == 0) return "R2";
    if (lvl == 1) return "R3";
    return "R4";
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v, int op, logic [7:0] v_lvl);
    int verdict;
    string t;
    logic [7:0] exp_err;
    op_valid  = v;
    op_code   = op[2:0];
    req_level = v_lvl;
    verdict = v ? judge(m_idx, op, v_lvl) : 0;
    t = tag_of(v, m_idx, op, verdict);
    exp_err = !v ? 8'h00 : (verdict == 1 ? 8'h50 : (verdict == 2 ? 8'h4C : 8'h00));
    @(negedge clk);
    chk(grant == (v && verdict == 0), t, "grant", grant, (v && verdict == 0));
    chk(deny == (v && verdict != 0), t, "deny", deny, (v && verdict != 0));
    chk(err_char == exp_err, t, "err_char", err_char, exp_err);
    chk(sec_level == idx_byte(m_idx), last_tag, "sec_level", sec_level, idx_byte(m_idx));
    chk(cfg_restore == m_restore, "R8", "cfg_restore", cfg_restore, m_restore);
    @(posedge clk);
    m_restore = v && (op == 3);
    if (v && verdict == 0 && op == 5) m_idx = target_of(v_lvl);
    if (v && op == 3) m_idx = 0;
    last_tag = t;
    #1;
  endtask

  task automatic sweep();
    for (int o = 0; o < 8; o++) if (o != 3 && o != 5) step(1, o, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(sec_level == 8'hFF, "R1", "sec_level", sec_level, 8'hFF);
    chk(!grant && !deny, "R1", "grant/deny", {grant, deny}, 0);
    chk(err_char == 8'h00, "R1", "err_char", err_char, 0);
    chk(!cfg_restore, "R1", "cfg_restore", cfg_restore, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    step(0, 5, 8'hFE);            // R9: strobe low, nothing moves
    sweep();                      // R2
    step(1, 5, 8'h12);            // R7 unrecognised
    step(1, 5, 8'hFF);            // R7 same level
    step(1, 5, 8'hFE);            // R6
    sweep();                      // R3
    step(1, 5, 8'hFF);            // R7 lowering
    step(1, 5, 8'hFE);            // R7 repeat
    step(1, 5, 8'hFC);            // R6
    sweep();                      // R4
    step(1, 5, 8'hFC);            // R7
    step(1, 5, 8'hFE);            // R7
    step(0, 3, 8'h00);            // R9
    step(1, 3, 8'h00);            // R8
    step(0, 0, 8'h00);
    step(1, 5, 8'hFC);            // R6 open straight to read/write-locked
    step(1, 3, 8'h00);            // R8
    step(1, 3, 8'h00);            // R8 back to back
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
        logic [7:0] pick;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (lfsr[9:8])
          2'd0: pick = 8'hFF;
          2'd1: pick = 8'hFE;
          2'd2: pick = 8'hFC;
          default: pick = lfsr[7:0];
        endcase
        if (lfsr[2:0] == 3'd3 && lfsr[12]) step(lfsr[4], 5, pick);
        else step(lfsr[4] | lfsr[11], int'(lfsr[2:0]), pick);
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule